// File: doc/BRIEF.md
# Modem Status Generator with Loopback and Change Flags

This block derives the 8-bit modem status value of a serial port from the stored modem control value, because the block has no physical modem inputs. When loopback is off, the four status lines are tied to fixed levels: carrier present and data set ready asserted, clear to send and ring low. When loopback is on, four control bits feed back into the status lines.

Each write to the control register can change the status lines. The block compares the lines before and after the write and sets sticky change flags in the low nibble of the status value. Ring indicate is flagged only when it falls. Reading the status value returns it as it stands, and the change flags are then cleared. A single summary flag, high whenever any change flag is set, goes to the port's interrupt logic.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the stored control value is 0x00, the status value is 0xA0 and the summary flag is low.
- R2: A control write stores only bits 4:0 of the written byte. Bits 7:5 of the stored control value always read 0.
- R3: With loopback off (control bit 4 = 0), status bits 7:4 are DCD=1 (bit 7), RI=0 (bit 6), DSR=1 (bit 5), CTS=0 (bit 4), whatever control bits 3:0 hold.
- R4: With loopback on (control bit 4 = 1), CTS (status bit 4) follows control bit 1, DSR (bit 5) follows control bit 0, RI (bit 6) follows control bit 2, and DCD (bit 7) follows control bit 3.
- R5: A control write that changes CTS, DSR or DCD sets that line's change flag: status bit 0 for CTS, bit 1 for DSR, bit 3 for DCD.
- R6: Status bit 2 is set by a control write only when RI goes from 1 to 0. A rise of RI leaves it unchanged.
- R7: Change flags are sticky. A write ORs new flags into the existing ones. Without a read, no flag ever clears.
- R8: A status read returns the current value in the same cycle and clears all four change flags on the following edge. Flags raised by a control write in the same cycle as the read are kept.
- R9: The summary flag is high exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Byte written to the control register |
| sts_rd_en | input | 1 | Read strobe for the status register (clears change flags) |
| sts_rd_data | output | 8 | Current status value |
| delta_any | output | 1 | High when any change flag is set |
| ctl_q | output | 8 | Stored control value |

## Verification
On every cycle, the assertions check the zero upper control bits, the fixed and loopback line levels, the summary flag, the stability of the flags when no access occurs, that no flag is lost on a write, clearing after a read, and the falling-edge rule for ring. Only the bench scenarios show that each control transition sets exactly the expected flag pattern. They also show flags accumulating across writes and a read that coincides with a write.

// File: rtl/msu_pkg.sv
package msu_pkg;
    localparam int CTL_W    = 8;
    localparam int CTL_KEEP = 5;
    localparam int LINE_N   = 4;
    localparam int LOOP_BIT = 4;
    // line index inside a status nibble
    localparam int IX_CTS = 0;
    localparam int IX_DSR = 1;
    localparam int IX_RI  = 2;
    localparam int IX_DCD = 3;
    localparam logic [CTL_W-1:0] KEEP_MASK = CTL_W'((1 << CTL_KEEP) - 1);
    // fixed line levels when loopback is off: DCD=1, RI=0, DSR=1, CTS=0
    localparam logic [LINE_N-1:0] IDLE_LINES = 4'b1010;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [LINE_N-1:0] delta;
    } msu_state_t;
endpackage

// File: rtl/msu_line_map.sv
module msu_line_map
    import msu_pkg::*;
(
    input  logic [CTL_W-1:0]  ctl,
    output logic [LINE_N-1:0] lines
);
    always_comb begin
        if (ctl[LOOP_BIT]) begin
            lines         = '0;
            lines[IX_CTS] = ctl[1];
            lines[IX_DSR] = ctl[0];
            lines[IX_RI]  = ctl[2];
            lines[IX_DCD] = ctl[3];
        end else begin
            lines = IDLE_LINES;
        end
    end
endmodule

// File: rtl/msu_change_detect.sv
module msu_change_detect
    import msu_pkg::*;
(
    input  logic [LINE_N-1:0] old_lines,
    input  logic [LINE_N-1:0] new_lines,
    output logic [LINE_N-1:0] chg
);
    for (genvar i = 0; i < LINE_N; i++) begin : g_bit
        if (i == IX_RI) begin : g_fall
            assign chg[i] = old_lines[i] & ~new_lines[i];
        end else begin : g_any
            assign chg[i] = old_lines[i] ^ new_lines[i];
        end
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    input  logic             sts_rd_en,
    output logic [CTL_W-1:0] sts_rd_data,
    output logic             delta_any,
    output logic [CTL_W-1:0] ctl_q
);
    msu_state_t state_d, state_q;

    logic [CTL_W-1:0]  ctl_new;
    logic [LINE_N-1:0] lines_cur, lines_new, chg;

    assign ctl_new = ctl_wr_data & KEEP_MASK;

    msu_line_map u_map_cur (.ctl(state_q.ctl), .lines(lines_cur));
    msu_line_map u_map_new (.ctl(ctl_new),     .lines(lines_new));

    msu_change_detect u_chg (
        .old_lines(lines_cur),
        .new_lines(lines_new),
        .chg      (chg)
    );

    always_comb begin
        state_d = state_q;
        if (sts_rd_en) begin
            state_d.delta = '0;
        end
        if (ctl_wr_en) begin
            state_d.ctl   = ctl_new;
            state_d.delta = state_d.delta | chg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sts_rd_data = {lines_cur, state_q.delta};
    assign delta_any   = |state_q.delta;
    assign ctl_q       = state_q.ctl;
endmodule

// File: rtl/msu_checker.sv
module msu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr_en,
    input logic       sts_rd_en,
    input logic [7:0] sts_rd_data,
    input logic       delta_any,
    input logic [7:0] ctl_q
);
    AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7:5] == 3'b000); // R2
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[4] |-> sts_rd_data[7:4] == 4'b1010); // R3
    AST_LOOP_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> sts_rd_data[7:4] == {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]}); // R4
    AST_RI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !sts_rd_en && !sts_rd_data[2]) |=>
        sts_rd_data[2] == ($past(sts_rd_data[6]) && !sts_rd_data[6])); // R6
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_en && !sts_rd_en) |=> $stable(sts_rd_data[3:0])); // R7
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !sts_rd_en) |=>
        (sts_rd_data[3:0] & $past(sts_rd_data[3:0])) == $past(sts_rd_data[3:0])); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd_en && !ctl_wr_en) |=> sts_rd_data[3:0] == 4'b0000); // R8
    AST_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        delta_any == (sts_rd_data[3:0] != 4'b0000)); // R9
endmodule

bind modem_status_unit msu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_en  (ctl_wr_en),
    .sts_rd_en  (sts_rd_en),
    .sts_rd_data(sts_rd_data),
    .delta_any  (delta_any),
    .ctl_q      (ctl_q)
);

// File: tb/modem_status_unit_test.sv
module modem_status_unit_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr_en;
    logic [7:0] ctl_wr_data;
    logic       sts_rd_en;
    logic [7:0] sts_rd_data;
    logic       delta_any;
    logic [7:0] ctl_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    modem_status_unit uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .sts_rd_en(sts_rd_en), .sts_rd_data(sts_rd_data),
        .delta_any(delta_any), .ctl_q(ctl_q)
    );

    // {written byte, expected control, expected status after the write}
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        {8'hFF, 8'h1F, 8'hF1},  // R4 R5 R6: loop on, CTS changes, RI rises (no flag)
        {8'h10, 8'h10, 8'h0F},  // R5 R6: all lines drop, RI falls
        {8'h14, 8'h14, 8'h40},  // R6: RI rise alone, no flag
        {8'h10, 8'h10, 8'h04},  // R6: RI fall alone
        {8'h19, 8'h19, 8'hAA},  // R4 R5: DCD and DSR rise
        {8'h09, 8'h09, 8'hA0},  // R3: loop off, same levels, no flag
        {8'hEF, 8'h0F, 8'hA0},  // R2 R3: upper bits dropped, idle levels
        {8'h12, 8'h12, 8'h1B},  // R5: DCD, DSR, CTS change
        {8'h00, 8'h00, 8'hAB}   // R5: back to idle
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [7:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic do_read(logic [7:0] exp);
        @(negedge clk);
        sts_rd_en = 1'b1;
        #1 check("R8 read value", sts_rd_data, exp);
        @(negedge clk);
        sts_rd_en = 1'b0;
        #1 check("R8 flags cleared", sts_rd_data, {exp[7:4], 4'h0});
        check("R9 summary low", {7'b0, delta_any}, 8'h00);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = 8'h00; sts_rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 control", ctl_q, 8'h00);
        check("R1 status", sts_rd_data, 8'hA0);
        check("R1 summary", {7'b0, delta_any}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][23:16]);
            #1;
            check("R2 control stored", ctl_q, VEC[i][15:8]);
            check("R5 status after write", sts_rd_data, VEC[i][7:0]);
            check("R9 summary", {7'b0, delta_any}, {7'b0, VEC[i][3:0] != 4'h0});
            do_read(VEC[i][7:0]);
        end

        // R7: flags accumulate across writes without a read
        do_write(8'h14);
        #1 check("R7 first write", sts_rd_data, 8'h4A);
        do_write(8'h10);
        #1 check("R7 flags ORed", sts_rd_data, 8'h0E);
        check("R9 summary high", {7'b0, delta_any}, 8'h01);
        repeat (3) @(negedge clk);
        #1 check("R7 idle hold", sts_rd_data, 8'h0E);

        // R8: read and write in the same cycle
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = 8'h1F; sts_rd_en = 1'b1;
        #1 check("R8 read during write", sts_rd_data, 8'h0E);
        @(negedge clk);
        ctl_wr_en = 1'b0; sts_rd_en = 1'b0;
        #1 check("R8 new flags kept", sts_rd_data, 8'hFB);

        // R7: write with no line change keeps existing flags
        do_write(8'h1F);
        #1 check("R7 unchanged write", sts_rd_data, 8'hFB);

        // R1: reset in mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 re-reset status", sts_rd_data, 8'hA0);
        check("R1 re-reset control", ctl_q, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule